// File: doc/BRIEF.md
# Note Duration and Gate Generator

This block paces the playback of a stored note sequence. At the start of each step it accepts a length code from the note memory over a valid/ready stream. It turns that code into a step period that grows exponentially: each code increment doubles the period, so the four codes of a 2-bit field give durations in the ratio 1:2:4:8 of a programmable base period. The block emits a one-cycle step tick at the start of every step. That tick advances the playback address counter, so the memory can present the next note's code.

With each tick the block raises a gate that marks the start of the note's envelope. The gate width is set separately from the period. It is always shortened so that the gate falls at least one cycle before the next tick. That guarantees a visible gap between consecutive notes.

The stream rules are as follows. `len_ready` is high only while `enable` is high and the generator is either idle or in the final cycle of a step. A code transfers on a cycle where `len_valid` and `len_ready` are both high. The source may hold `len_valid` high while it waits. If no code is offered when a step ends, the generator goes idle, emits no tick and waits. Once accepted, a code is not sampled again. `len_ready` depends on `enable` and internal state only, never on `len_valid`.

Top module: `note_timing_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset with `enable` low, `step_tick`, `gate` and `len_ready` are all low.
- R2: A step started by an accepted code C lasts P = B << C cycles, where B is `base_period` sampled at the acceptance. If another code is accepted in the step's last cycle, the next `step_tick` comes exactly P cycles after the previous one.
- R3: Code values 0, 1, 2 and 3 give step periods of 1, 2, 4 and 8 times the base period: each increment of the code doubles the period.
- R4: `gate` rises in the same cycle as `step_tick` and stays high for W consecutive cycles, where W is `gate_width` sampled at the acceptance.
- R5: The gate length is min(W, P-1), so `gate` is low in the last cycle of every step.
- R6: A sampled `gate_width` of 0 gives a step with no gate at all.
- R7: `len_ready` is high exactly when `enable` is high and the generator is idle or in the final cycle of a step. `step_tick` occurs only in the cycle after a transfer (`len_valid` and `len_ready` both high).
- R8: When no code is offered at the end of a step, the generator goes idle, holds `len_ready` high while enabled, and emits no tick until a code transfers.
- R9: With `enable` low, no code is accepted and `len_ready` stays low; a step already in progress still runs to its end, with no further tick.
- R10: A `base_period` of 0 is treated as 1, so code 0 with base 0 gives a tick on every cycle and no gate.
- R11: Changes to `base_period` and `gate_width` during a step do not affect that step; they apply from the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows new steps to start |
| base_period | input | BASE_W (16) | Base step period in cycles |
| gate_width | input | GATE_W (8) | Requested gate length in cycles |
| len_valid | input | 1 | Length code is valid |
| len_ready | output | 1 | Generator accepts a length code this cycle |
| len_code | input | LEN_W (2) | Length code; period = base << code |
| step_tick | output | 1 | One-cycle pulse at the start of each step |
| gate | output | 1 | Envelope gate for the current note |

## Verification
Several properties are checked on every cycle:
- A tick always follows a transfer.
- `len_ready` never rises without `enable`.
- The gate rises only together with a tick and is low in the cycle before any tick.
- A zero gate width leaves the tick cycle ungated.
- No tick arrives sooner than the captured period after the previous one.

Other behaviour can only be shown by the bench's scenarios:
- The exact 1:2:4:8 spacing.
- The gate lengths under clamping.
- Idle stalls when no code is offered.
- Completion of a step after `enable` drops.
- Insensitivity to mid-step changes of the base period and gate width.

// File: rtl/note_timing_pkg.sv
package note_timing_pkg;
  typedef enum logic {
    STEP_IDLE = 1'b0,
    STEP_RUN  = 1'b1
  } step_state_e;
endpackage

// File: rtl/ntg_period_sel.sv
// Exponential period selection: one pre-shifted candidate per code value.
module ntg_period_sel #(
  parameter int BASE_W = 16,
  parameter int LEN_W  = 2,
  parameter int PER_W  = 19
) (
  input  logic [BASE_W-1:0] base_period,
  input  logic [LEN_W-1:0]  len_code,
  output logic [PER_W-1:0]  period
);
  localparam int NCODES = 1 << LEN_W;

  logic [BASE_W-1:0] base_eff;
  logic [PER_W-1:0]  cand [NCODES];

  // A zero base would give a zero-length step; promote it to one cycle.
  assign base_eff = (base_period == '0) ? BASE_W'(1) : base_period;

  for (genvar i = 0; i < NCODES; i++) begin : g_cand
    assign cand[i] = PER_W'(base_eff) << i;
  end

  assign period = cand[len_code];
endmodule

// File: rtl/ntg_step_timer.sv
// Step sequencing: handshake at step boundaries, elapsed counter, tick.
module ntg_step_timer
  import note_timing_pkg::*;
#(
  parameter int PER_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             len_valid,
  input  logic [PER_W-1:0] period_in,
  output logic             len_ready,
  output logic             load,
  output logic             step_tick,
  output logic             running,
  output logic [PER_W-1:0] elapsed
);
  step_state_e      state_q;
  logic [PER_W-1:0] el_q;
  logic [PER_W-1:0] per_q;
  logic             last_c;

  assign running   = (state_q == STEP_RUN);
  assign last_c    = running && (el_q == per_q - 1'b1);
  assign len_ready = enable && (!running || last_c);
  assign load      = len_ready && len_valid;
  assign step_tick = running && (el_q == '0);
  assign elapsed   = el_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= STEP_IDLE;
      el_q    <= '0;
      per_q   <= PER_W'(1);
    end else if (load) begin
      state_q <= STEP_RUN;
      el_q    <= '0;
      per_q   <= period_in;
    end else if (last_c) begin
      state_q <= STEP_IDLE;
    end else if (running) begin
      el_q <= el_q + 1'b1;
    end
  end
endmodule

// File: rtl/ntg_gate_shaper.sv
// Gate length latched per step, clamped to end before the step's last cycle.
module ntg_gate_shaper #(
  parameter int PER_W  = 19,
  parameter int GATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PER_W-1:0]  period_in,
  input  logic [GATE_W-1:0] gate_width,
  input  logic              running,
  input  logic [PER_W-1:0]  elapsed,
  output logic              gate
);
  logic [PER_W-1:0] gw_ext;
  logic [PER_W-1:0] limit;
  logic [PER_W-1:0] glen_next;
  logic [PER_W-1:0] glen_q;

  assign gw_ext    = PER_W'(gate_width);
  assign limit     = period_in - 1'b1;
  assign glen_next = (gw_ext < limit) ? gw_ext : limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glen_q <= '0;
    end else if (load) begin
      glen_q <= glen_next;
    end
  end

  assign gate = running && (elapsed < glen_q);
endmodule

// File: rtl/note_timing_gen.sv
module note_timing_gen #(
  parameter int BASE_W = 16,
  parameter int LEN_W  = 2,
  parameter int GATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [BASE_W-1:0] base_period,
  input  logic [GATE_W-1:0] gate_width,
  input  logic              len_valid,
  output logic              len_ready,
  input  logic [LEN_W-1:0]  len_code,
  output logic              step_tick,
  output logic              gate
);
  localparam int NCODES = 1 << LEN_W;
  localparam int PER_W  = BASE_W + NCODES - 1;

  logic [PER_W-1:0] period;
  logic [PER_W-1:0] elapsed;
  logic             load;
  logic             running;

  ntg_period_sel #(
    .BASE_W(BASE_W), .LEN_W(LEN_W), .PER_W(PER_W)
  ) u_period (
    .base_period(base_period),
    .len_code   (len_code),
    .period     (period)
  );

  ntg_step_timer #(
    .PER_W(PER_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .len_valid(len_valid),
    .period_in(period),
    .len_ready(len_ready),
    .load     (load),
    .step_tick(step_tick),
    .running  (running),
    .elapsed  (elapsed)
  );

  ntg_gate_shaper #(
    .PER_W(PER_W), .GATE_W(GATE_W)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .period_in (period),
    .gate_width(gate_width),
    .running   (running),
    .elapsed   (elapsed),
    .gate      (gate)
  );
endmodule

// File: rtl/note_timing_checks.sv
module note_timing_checks #(
  parameter int BASE_W = 16,
  parameter int LEN_W  = 2,
  parameter int GATE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [BASE_W-1:0] base_period,
  input logic [GATE_W-1:0] gate_width,
  input logic              len_valid,
  input logic              len_ready,
  input logic [LEN_W-1:0]  len_code,
  input logic              step_tick,
  input logic              gate
);
  localparam int PER_W = BASE_W + (1 << LEN_W) - 1;
  localparam int AGE_W = PER_W + 1;

  logic             hs;
  logic [PER_W-1:0] nxt_per;
  logic [PER_W-1:0] cur_per;
  logic [AGE_W-1:0] age;
  logic             live;
  logic [BASE_W-1:0] b_eff;

  assign hs    = len_valid && len_ready;
  assign b_eff = (base_period == '0) ? BASE_W'(1) : base_period;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_per <= '0;
      cur_per <= '0;
      age     <= '0;
      live    <= 1'b0;
    end else begin
      if (hs) nxt_per <= PER_W'(b_eff) << len_code;
      if (step_tick) begin
        cur_per <= nxt_per;
        age     <= AGE_W'(1);
        live    <= 1'b1;
      end else if (age != '1) begin
        age <= age + 1'b1;
      end
    end
  end

  assert_tick_follows_transfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_tick |-> $past(len_valid && len_ready));

  assert_ready_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    len_ready |-> enable);

  assert_gate_rises_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> step_tick);

  assert_gate_low_before_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_tick |-> !$past(gate));

  assert_zero_width_no_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && gate_width == '0) |=> !gate);

  assert_step_not_short_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_tick && live) |-> (age >= {1'b0, cur_per}));
endmodule

bind note_timing_gen note_timing_checks #(
  .BASE_W(BASE_W), .LEN_W(LEN_W), .GATE_W(GATE_W)
) u_note_timing_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .base_period(base_period),
  .gate_width (gate_width),
  .len_valid  (len_valid),
  .len_ready  (len_ready),
  .len_code   (len_code),
  .step_tick  (step_tick),
  .gate       (gate)
);

// File: tb/test_note_timing_gen.sv
module test_note_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] base_period = '0;
  logic [7:0]  gate_width = '0;
  logic        len_valid = 1'b0;
  logic        len_ready;
  logic [1:0]  len_code = '0;
  logic        step_tick;
  logic        gate;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  bit m_run = 0;
  int m_el = 0, m_per = 1, m_glen = 0;
  // observation counters
  int cyc = 0, last_tick_cyc = -1, last_gap = 0;
  int cur_glen = 0, last_glen = 0;
  int n_tick = 0, n_gate = 0, n_ready = 0;
  bit saw_tick = 0;

  always #2 clk = ~clk;

  note_timing_gen i_note_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .base_period(base_period),
    .gate_width(gate_width), .len_valid(len_valid), .len_ready(len_ready),
    .len_code(len_code), .step_tick(step_tick), .gate(gate)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int exp_period(int b, int c);
    return ((b == 0) ? 1 : b) << c;
  endfunction

  function automatic int exp_glen(int w, int p);
    return (w < p - 1) ? w : p - 1;
  endfunction

  // Check current cycle against the model, update the model, pass one edge.
  task automatic cycle();
    bit er, et, eg;
    #1;
    er = enable && (!m_run || m_el == m_per - 1);
    et = m_run && m_el == 0;
    eg = m_run && m_el < m_glen;
    chk("R7", "len_ready", int'(len_ready), int'(er));
    chk("R2", "step_tick", int'(step_tick), int'(et));
    chk("R4", "gate", int'(gate), int'(eg));
    saw_tick = step_tick;
    if (step_tick) begin
      n_tick++;
      if (last_tick_cyc >= 0) last_gap = cyc - last_tick_cyc;
      last_tick_cyc = cyc;
    end
    if (gate) begin
      n_gate++;
      cur_glen++;
    end else if (cur_glen > 0) begin
      last_glen = cur_glen;
      cur_glen = 0;
    end
    if (len_ready) n_ready++;
    if (len_valid && er) begin
      m_run = 1; m_el = 0;
      m_per = exp_period(int'(base_period), int'(len_code));
      m_glen = exp_glen(int'(gate_width), m_per);
    end else if (m_run && m_el == m_per - 1) begin
      m_run = 0;
    end else if (m_run) begin
      m_el++;
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    #600000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int gaps[4];
    int t0, r0, g0;
    void'($urandom(1979));
    repeat (4) @(negedge clk);
    // R1: outputs idle during and right after reset
    chk("R1", "tick in reset", int'(step_tick), 0);
    chk("R1", "gate in reset", int'(gate), 0);
    rst_n = 1'b1;
    #1;
    chk("R1", "tick after reset", int'(step_tick), 0);
    chk("R1", "gate after reset", int'(gate), 0);
    chk("R1", "ready after reset", int'(len_ready), 0);
    run(2);

    // R10: base 0 behaves as 1
    enable = 1; len_valid = 1; base_period = 0; len_code = 0; gate_width = 5;
    g0 = n_gate;
    run(10);
    chk("R10", "tick gap with base 0", last_gap, 1);
    chk("R10", "gate count with base 0", n_gate - g0, 0);

    // R3: exponential doubling across codes
    base_period = 3; gate_width = 1;
    for (int c = 0; c < 4; c++) begin
      len_code = 2'(c);
      run((3 << c) * 2 + 2);
      gaps[c] = last_gap;
      chk("R3", "gap for code", gaps[c], 3 << c);
      if (c > 0) chk("R3", "doubling ratio", gaps[c], 2 * gaps[c-1]);
    end

    // R4/R5/R6: gate length and clamping
    base_period = 8; len_code = 0; gate_width = 3;
    run(40);
    chk("R4", "gate length", last_glen, 3);
    gate_width = 20;
    run(40);
    chk("R5", "clamped gate length", last_glen, 7);
    gate_width = 0;
    run(20);
    g0 = n_gate;
    run(30);
    chk("R6", "gate with zero width", n_gate - g0, 0);

    // R8: starvation leaves generator idle and waiting
    gate_width = 2;
    len_valid = 0;
    run(20);
    t0 = n_tick; r0 = n_ready;
    run(20);
    chk("R8", "ticks while starved", n_tick - t0, 0);
    chk("R8", "ready while idle", n_ready - r0, 20);
    len_valid = 1;
    run(3);

    // R9: enable low finishes the step, accepts nothing
    enable = 0;
    t0 = n_tick; r0 = n_ready;
    run(30);
    chk("R9", "ticks while disabled", n_tick - t0, 0);
    chk("R9", "ready while disabled", n_ready - r0, 0);
    chk("R9", "generator idle", int'(m_run), 0);

    // R11: mid-step changes do not affect the running step
    enable = 1; base_period = 10; gate_width = 4; len_code = 0;
    saw_tick = 0;
    for (int i = 0; i < 40 && !saw_tick; i++) cycle();
    base_period = 2; gate_width = 9;
    run(10);
    chk("R11", "gap of running step", last_gap, 10);
    chk("R11", "gate of running step", last_glen, 4);

    // Random mix, checked per cycle against the model (R2, R4, R7)
    for (int i = 0; i < 3000; i++) begin
      if (i % 17 == 0) begin
        base_period = 16'($urandom_range(0, 12));
        gate_width  = 8'($urandom_range(0, 15));
      end
      enable    = ($urandom_range(0, 9) != 0);
      len_valid = ($urandom_range(0, 9) < 7);
      len_code  = 2'($urandom_range(0, 3));
      cycle();
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule